// File: doc/BRIEF.md
# Dual Shuffle-Exchange Error-Correcting Node Router

This block makes the routing decision for one 4x4 switching node in a network that overlays a shuffle-exchange fabric on an unshuffle-exchange fabric. Up to four cells arrive in one cycle. Each cell carries a stack of 2-bit routing symbols, the number of symbols on that stack, and a saved copy of its starting tag. The node also receives its own label. The block gives each cell exactly one of the four output ports. It then rewrites the cell's stack: the top symbol is popped when the cell gets the port it asked for, and a correction symbol is pushed when the cell is sent elsewhere. When the stack is already full, the stack is reloaded from the saved tag. The block also flags a cell as delivered when it uses up its last symbol, and it computes the label of the node the cell reaches at the next stage.

The top symbol of the stack always sits in bits [1:0] of the tag field, so a pop is a right shift and a push is a left shift. Ports 0 and 1 lead to the next stage over the unshuffle wiring, and ports 2 and 3 lead over the shuffle wiring. Because the correction symbol names the link that leads back, a misrouted cell is sent straight back to the node where the error happened one stage later. It does not restart its route from the beginning. The wiring between stages lies outside this block. Results are registered and indexed by output port, so they appear one clock after the inputs.

Top module: `dsx_route_node`

## Requirements
- R1: While reset is asserted, and after it, before any cell has been presented, every out_vld and out_dlv bit is 0.
- R2: A valid cell asks for port 2*c + r, where {c,r} is bits [1:0] of its tag. Cells are served in input order 0, 1, 2, 3, and a cell whose requested port is still free gets that port.
- R3: A cell whose requested port is already taken gets the lowest-numbered port that is still free. Every valid input appears on exactly one output port, one clock later.
- R4: A cell that gets its requested port with depth k > 1 leaves with its tag shifted right by two bits, depth k-1, and out_dlv 0.
- R5: A cell that gets its requested port with depth k = 1 leaves with out_dlv 1, depth 0 and tag 0.
- R6: A cell sent to port 0 or 1 other than the port it asked for, with k < N, leaves with depth k+1 and tag {tag[2N-3:0], 1, node_lab[0]}.
- R7: A cell sent to port 2 or 3 other than the port it asked for, with k < N, leaves with depth k+1 and tag {tag[2N-3:0], 0, node_lab[N-2]}.
- R8: A cell sent to a port other than the one it asked for, with k = N, leaves with its tag equal to its saved original tag and depth N.
- R9: For a cell leaving on port {c,r}, out_lab is {r, node_lab[N-2:1]} when c = 0 and {node_lab[N-3:0], r} when c = 1. node_lab[N-2] is the first label bit. The original tag passes through unchanged.
- R10: All fields of an output port that carries no cell are 0.
- R11: If a misrouted cell is presented to the node named by its out_lab, it leaves that node with the tag and depth it had before the misroute, and its out_lab equals the label of the node where it was misrouted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 4 | Cell present on each input |
| in_tag | input | 4 x 2N | Symbol stack per input, top symbol in bits [1:0] |
| in_dep | input | 4 x clog2(N+1) | Stack depth per input (1..N when valid) |
| in_orig | input | 4 x 2N | Saved starting tag per input |
| node_lab | input | N-1 | Label of this node, first bit is the MSB |
| out_vld | output | 4 | Cell present on each output port |
| out_tag | output | 4 x 2N | Updated symbol stack per output port |
| out_dep | output | 4 x clog2(N+1) | Updated depth per output port |
| out_orig | output | 4 x 2N | Saved starting tag per output port |
| out_lab | output | 4 x (N-1) | Label of the next-stage node per output port |
| out_dlv | output | 4 | Cell on this port reaches its destination |

## Verification
The bench drives several cells that all ask for the same port. A design with the wrong priority order or the wrong fallback choice would place the losing cells on the wrong ports, or would drop one of them. Misrouted cells are tested at depth below N and at depth N, and on both port halves. A design that mixed up the two correction symbols, or that pushed a symbol onto a full stack, would fail there. The bench also runs a two-stage round trip, which shows whether the pushed symbol really leads back to the node where the error happened. A long stream of random cells is compared with a behavioural model on every clock.

// File: rtl/dsx_route_node.sv
module dsx_route_node #(
  parameter int N = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [3:0]                             in_vld,
  input  logic [3:0][2*N-1:0]                    in_tag,
  input  logic [3:0][$clog2(N+1)-1:0]            in_dep,
  input  logic [3:0][2*N-1:0]                    in_orig,
  input  logic [N-2:0]                           node_lab,
  output logic [3:0]                             out_vld,
  output logic [3:0][2*N-1:0]                    out_tag,
  output logic [3:0][$clog2(N+1)-1:0]            out_dep,
  output logic [3:0][2*N-1:0]                    out_orig,
  output logic [3:0][N-2:0]                      out_lab,
  output logic [3:0]                             out_dlv
);
  localparam int LW = N - 1;
  localparam int TW = 2 * N;
  localparam int KW = $clog2(N + 1);

  logic [3:0]          busy, hit;
  logic [3:0][1:0]     sel;
  logic [3:0]          n_vld, n_dlv;
  logic [3:0][TW-1:0]  n_tag, n_orig;
  logic [3:0][KW-1:0]  n_dep;
  logic [3:0][LW-1:0]  n_lab;

  always_comb begin
    busy = '0;
    sel  = '0;
    hit  = '0;
    for (int i = 0; i < 4; i++) begin
      if (in_vld[i]) begin
        if (!busy[in_tag[i][1:0]]) begin
          sel[i] = in_tag[i][1:0];
          hit[i] = 1'b1;
        end else begin
          for (int j = 3; j >= 0; j--)
            if (!busy[j]) sel[i] = 2'(j);
        end
        busy[sel[i]] = 1'b1;
      end
    end
  end

  always_comb begin
    logic [1:0] p;
    n_vld  = '0;
    n_dlv  = '0;
    n_tag  = '0;
    n_orig = '0;
    n_dep  = '0;
    n_lab  = '0;
    for (int i = 0; i < 4; i++) begin
      p = sel[i];
      if (in_vld[i]) begin
        n_vld[p]  = 1'b1;
        n_orig[p] = in_orig[i];
        n_lab[p]  = p[1] ? {node_lab[LW-2:0], p[0]} : {p[0], node_lab[LW-1:1]};
        if (hit[i]) begin
          if (in_dep[i] == KW'(1)) begin
            n_dlv[p] = 1'b1;
          end else begin
            n_tag[p] = in_tag[i] >> 2;
            n_dep[p] = in_dep[i] - KW'(1);
          end
        end else if (in_dep[i] == KW'(N)) begin
          n_tag[p] = in_orig[i];
          n_dep[p] = KW'(N);
        end else begin
          n_tag[p] = {in_tag[i][TW-3:0], p[1] ? {1'b0, node_lab[LW-1]} : {1'b1, node_lab[0]}};
          n_dep[p] = in_dep[i] + KW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= '0;
      out_dlv  <= '0;
      out_tag  <= '0;
      out_orig <= '0;
      out_dep  <= '0;
      out_lab  <= '0;
    end else begin
      out_vld  <= n_vld;
      out_dlv  <= n_dlv;
      out_tag  <= n_tag;
      out_orig <= n_orig;
      out_dep  <= n_dep;
      out_lab  <= n_lab;
    end
  end

  p_cell_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $countones(out_vld) == $countones($past(in_vld)));

  p_first_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld[0] |=> out_vld[$past(in_tag[0][1:0])]);

  for (genvar g = 0; g < 4; g++) begin : g_chk
    p_dlv_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_dlv[g] |-> out_vld[g] && out_dep[g] == '0);
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !out_vld[g] |-> out_dep[g] == '0 && out_tag[g] == '0 && !out_dlv[g]);
    p_live_depth_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[g] && !out_dlv[g] |-> out_dep[g] != '0 && out_dep[g] <= KW'(N));
  end
endmodule

// File: tb/test_dsx_route_node.sv
module test_dsx_route_node;
  localparam int N  = 3;
  localparam int LW = N - 1;
  localparam int TW = 2 * N;
  localparam int KW = $clog2(N + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] in_vld = '0;
  logic [3:0][TW-1:0] in_tag = '0, in_orig = '0;
  logic [3:0][KW-1:0] in_dep = '0;
  logic [LW-1:0] node_lab = '0;
  logic [3:0] out_vld, out_dlv;
  logic [3:0][TW-1:0] out_tag, out_orig;
  logic [3:0][KW-1:0] out_dep;
  logic [3:0][LW-1:0] out_lab;

  int checks = 0, fails = 0;
  bit done = 0;
  int e_vld[4], e_tag[4], e_dep[4], e_orig[4], e_lab[4], e_dlv[4];

  always #2 clk = ~clk;

  dsx_route_node #(.N(N)) i_dsx_route_node (
    .clk, .rst_n, .in_vld, .in_tag, .in_dep, .in_orig, .node_lab,
    .out_vld, .out_tag, .out_dep, .out_orig, .out_lab, .out_dlv);

  task automatic check(input string req, input int got, input int exp, input string what);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got=%0d exp=%0d", req, what, got, exp);
    end
  endtask

  task automatic model();
    int freep[4];
    int w, p, h, t, d, L, c, r;
    for (int q = 0; q < 4; q++) begin
      freep[q] = 1; e_vld[q] = 0; e_tag[q] = 0; e_dep[q] = 0;
      e_orig[q] = 0; e_lab[q] = 0; e_dlv[q] = 0;
    end
    L = int'(node_lab);
    for (int i = 0; i < 4; i++) begin
      if (!in_vld[i]) continue;
      t = int'(in_tag[i]); d = int'(in_dep[i]);
      w = t % 4; h = 0; p = -1;
      if (freep[w] == 1) begin p = w; h = 1; end
      else for (int q = 0; q < 4 && p < 0; q++) if (freep[q] == 1) p = q;
      freep[p] = 0;
      c = p / 2; r = p % 2;
      e_vld[p] = 1;
      e_orig[p] = int'(in_orig[i]);
      e_lab[p] = (c == 0) ? ((r << (LW - 1)) | (L >> 1)) : (((L << 1) | r) % (1 << LW));
      if (h == 1) begin
        if (d == 1) e_dlv[p] = 1;
        else begin e_tag[p] = t / 4; e_dep[p] = d - 1; end
      end else if (d == N) begin
        e_tag[p] = int'(in_orig[i]); e_dep[p] = N;
      end else begin
        e_tag[p] = (t * 4 + ((c == 0) ? (2 + (L % 2)) : ((L >> (LW - 1)) % 2))) % (1 << TW);
        e_dep[p] = d + 1;
      end
    end
  endtask

  task automatic cycle(input string req);
    model();
    @(negedge clk);
    for (int q = 0; q < 4; q++) begin
      checks++;
      if (out_vld[q] != e_vld[q][0] || int'(out_tag[q]) != e_tag[q] || int'(out_dep[q]) != e_dep[q] ||
          int'(out_orig[q]) != e_orig[q] || int'(out_lab[q]) != e_lab[q] || out_dlv[q] != e_dlv[q][0]) begin
        fails++;
        $display("FAIL %s port%0d got vld=%0d tag=%0d dep=%0d orig=%0d lab=%0d dlv=%0d exp vld=%0d tag=%0d dep=%0d orig=%0d lab=%0d dlv=%0d",
          req, q, out_vld[q], out_tag[q], out_dep[q], out_orig[q], out_lab[q], out_dlv[q],
          e_vld[q], e_tag[q], e_dep[q], e_orig[q], e_lab[q], e_dlv[q]);
      end
    end
  endtask

  task automatic put(input int i, input int t, input int d, input int o);
    in_vld[i] = 1'b1; in_tag[i] = TW'(t); in_dep[i] = KW'(d); in_orig[i] = TW'(o);
  endtask

  task automatic clear();
    in_vld = '0; in_tag = '0; in_dep = '0; in_orig = '0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int sv_tag, sv_dep, lab_a, p0tag, p0dep, p0lab, p0orig;
    repeat (3) @(negedge clk);
    check("R1", int'(out_vld), 0, "vld in reset");
    check("R1", int'(out_dlv), 0, "dlv in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(out_vld), 0, "vld after reset");

    node_lab = 2'b10; put(0, 6'b000111, 2, 9);
    cycle("R4");
    check("R4", int'(out_tag[3]), 1, "popped tag");
    check("R9", int'(out_lab[3]), 1, "shuffle label");

    clear(); node_lab = 2'b10; put(0, 6'b000001, 1, 5);
    cycle("R5");
    check("R5", int'(out_dlv[1]), 1, "delivered");
    check("R9", int'(out_lab[1]), 3, "unshuffle label");

    clear(); cycle("R10");

    clear(); node_lab = 2'b01;
    for (int i = 0; i < 4; i++) put(i, 6'b000110, 2, i + 20);
    cycle("R2");
    check("R2", int'(out_orig[2]), 20, "input 0 wins port 2");
    check("R3", int'(out_orig[0]), 21, "first loser to port 0");
    check("R6", int'(out_tag[0]), 6'b011011, "push 1,x_last");
    check("R7", int'(out_tag[3]), 6'b011000, "push 0,x_first");

    clear(); node_lab = 2'b11;
    put(0, 6'b010101, 3, 33); put(1, 6'b000001, 3, 44); put(2, 6'b001101, 2, 7);
    cycle("R8");
    check("R8", int'(out_tag[0]), 44, "reset to original");
    check("R8", int'(out_dep[0]), N, "depth full");

    clear(); lab_a = 2'b01; node_lab = 2'(lab_a);
    sv_tag = 6'b000010; sv_dep = 1;
    put(0, 6'b001110, 2, 1); put(1, sv_tag, sv_dep, 2);
    cycle("R11");
    p0tag = int'(out_tag[0]); p0dep = int'(out_dep[0]);
    p0lab = int'(out_lab[0]); p0orig = int'(out_orig[0]);
    clear(); node_lab = 2'(p0lab); put(0, p0tag, p0dep, p0orig);
    cycle("R11");
    check("R11", int'(out_vld[2 | (lab_a % 2)]), 1, "back-link port");
    check("R11", int'(out_tag[2 | (lab_a % 2)]), sv_tag, "restored tag");
    check("R11", int'(out_dep[2 | (lab_a % 2)]), sv_dep, "restored depth");
    check("R11", int'(out_lab[2 | (lab_a % 2)]), lab_a, "returned node");

    for (int n = 0; n < 400; n++) begin
      clear();
      node_lab = LW'($urandom);
      for (int i = 0; i < 4; i++) begin
        int d;
        if ($urandom % 4 == 0) continue;
        d = 1 + int'($urandom % N);
        put(i, int'($urandom % (1 << (2 * d))), d, int'($urandom % (1 << TW)));
      end
      cycle("R3");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule